// File: doc/BRIEF.md
# T=0 Card-Side Command Responder

This block is the protocol engine inside a simple contact smart card that uses the T=0 character protocol. It sits above a half-duplex byte UART and deals in whole bytes only. Received bytes arrive as a one-cycle strobe with data. Outgoing bytes are handed over through a request that is raised only while the UART says it can take a byte.

Once reset is released the engine waits a fixed number of clock cycles and then sends a two-byte answer-to-reset. It then loops. Each pass collects a five-byte command header, reacts to it and goes back for the next header. Two commands are understood. Write-buffer fills an internal 256-byte store from address zero. Read-buffer returns the leading bytes of that store. Both are acknowledged with a procedure byte that repeats the instruction byte and end with a success status word. Any other header draws an error status word and nothing else.

Top module: `t0_card_engine`

## Requirements
- R1: While `rst_n` is sampled low, `tx_req` is low and the store is cleared to 0x00. Reset during any phase restarts the sequence from the answer-to-reset delay.
- R2: `tx_req` stays low for the first 400 rising edges after reset release. The first byte can be requested in the cycle that follows the 400th edge.
- R3: The answer-to-reset is exactly two bytes: 0x3B first, then 0x00.
- R4: `tx_req` is high only in cycles where `tx_ready` is high, and each such cycle hands over the byte on `tx_data`. A byte not yet handed over keeps its value on `tx_data` until it is taken.
- R5: Header bytes are taken, one per `rx_valid` cycle, in the order CLA, INS, P1, P2, P3. For a recognised header the first byte sent is a procedure byte equal to INS.
- R6: The header CLA,INS,P1,P2 = 0x00,0x0C,0x00,0x00 (as a 32-bit word 0x000C0000) is write-buffer. After the procedure byte, the next P3 received bytes go to store addresses 0, 1, 2 and upward. Then 0x90 and 0x00 are sent.
- R7: A write-buffer with P3 = 0 stores nothing. The procedure byte is followed at once by 0x90 and 0x00.
- R8: The header 0x000C0000 with INS replaced by 0x0A (word 0x000A0000) is read-buffer. After the procedure byte, store bytes 0 to P3-1 are sent in address order, then 0x90 and 0x00.
- R9: A read-buffer with P3 = 0 sends all 256 store bytes before the status word.
- R10: Any other header gets no procedure byte. The reply is 0x69 then 0x86.
- R11: After the last status byte is handed over, the engine waits for a new header. Bytes that arrive while it is sending, including in the cycle the last status byte is taken, are dropped and never counted as header bytes.
- R12: Store locations not written since reset read back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | UART can accept a byte this cycle |
| tx_req | output | 1 | Byte on `tx_data` is handed over this cycle |
| tx_data | output | 8 | Byte to send |

## Verification
Reception and transmission share a half-duplex channel. Two things can therefore happen in the same cycle: the last status byte is handed over, and a byte strobe arrives that the engine must not take as the first byte of the next header. The bench provokes this in one phase by raising `rx_valid` in every cycle the engine is sending, so the final handover always meets a strobe. In other phases `tx_ready` and the strobes follow a pseudo-random pattern. A behavioural model built on queues predicts `tx_req` and `tx_data` for every cycle, and the verdict comes from comparing them each cycle. A dropped or wrongly taken byte then shows up as a wrong procedure byte or a wrong status word on the following command.

// File: rtl/t0_pkg.sv
// Shared constants and the sequencing state type of the T=0 responder.
// Assumes 8-bit characters; command words pack CLA,INS,P1,P2 MSB first.
package t0_pkg;

    localparam logic [7:0]  ATR_FIRST = 8'h3B;
    localparam logic [7:0]  ATR_LAST  = 8'h00;
    localparam logic [7:0]  SW_OK_HI  = 8'h90;
    localparam logic [7:0]  SW_OK_LO  = 8'h00;
    localparam logic [7:0]  SW_BAD_HI = 8'h69;
    localparam logic [7:0]  SW_BAD_LO = 8'h86;
    localparam logic [31:0] CMD_WRITE = 32'h000C0000;
    localparam logic [31:0] CMD_READ  = 32'h000A0000;

    typedef enum logic [3:0] {
        ST_WAIT,   // answer-to-reset delay
        ST_ATR0,   // first answer-to-reset byte
        ST_ATR1,   // second answer-to-reset byte
        ST_HDR,    // collecting the five header bytes
        ST_PROC,   // procedure byte (INS echo)
        ST_WR,     // receiving write data
        ST_RD,     // sending store data
        ST_SW1,    // status word, high byte
        ST_SW2     // status word, low byte
    } t0_state_e;

endpackage

// File: rtl/t0_atr_timer.sv
// Counts clock cycles after reset release and gives a single-cycle pulse
// in the cycle before the count reaches DELAY. Assumes DELAY >= 2.
// The count then saturates until the next reset.
module t0_atr_timer #(
    parameter int DELAY = 400
) (
    input  logic clk,
    input  logic rst_n,
    output logic expire
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt;

    // Advance the cycle count until it saturates at DELAY.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != CW'(DELAY))
            cnt <= cnt + 1'b1;
    end

    assign expire = (cnt == CW'(DELAY - 1));
endmodule

// File: rtl/t0_hdr_capture.sv
// Collects a five-byte T=0 header. The first four bytes are kept; the
// fifth (P3) is flagged through `last` so the caller can take it from
// the input. Decodes the kept bytes against the two known commands.
module t0_hdr_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic [7:0] byte_in,
    output logic       last,
    output logic       cmd_wr,
    output logic       cmd_rd,
    output logic [7:0] ins
);
    import t0_pkg::*;

    logic [2:0] pos;
    logic [7:0] hb [4];

    // Store each header byte at its position; wrap after the fifth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            for (int i = 0; i < 4; i++) hb[i] <= '0;
        end else if (shift_en) begin
            if (pos == 3'd4) begin
                pos <= '0;
            end else begin
                hb[pos[1:0]] <= byte_in;
                pos          <= pos + 1'b1;
            end
        end
    end

    // Flag the P3 byte and decode the stored command word.
    always_comb begin
        last   = shift_en && (pos == 3'd4);
        cmd_wr = ({hb[0], hb[1], hb[2], hb[3]} == CMD_WRITE);
        cmd_rd = ({hb[0], hb[1], hb[2], hb[3]} == CMD_READ);
        ins    = hb[1];
    end
endmodule

// File: rtl/t0_buffer_ram.sv
// Byte store with one synchronous write port and one combinational read
// port. Reset clears every location so unwritten reads are defined.
module t0_buffer_ram #(
    parameter int DEPTH = 256,
    parameter int W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write one location when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/t0_card_engine.sv
// Card-side T=0 responder. Sends the answer-to-reset after a delay, then
// serves write-buffer and read-buffer commands from an internal store.
// Assumes the UART gives one rx_valid strobe per byte and takes a byte
// in any cycle where tx_ready and tx_req are both high.
module t0_card_engine #(
    parameter int ATR_DELAY = 400,
    parameter int DEPTH     = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_ready,
    output logic       tx_req,
    output logic [7:0] tx_data
);
    import t0_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int IW = AW + 1;

    t0_state_e     state;
    logic [IW-1:0] idx;
    logic [IW-1:0] len;
    logic          is_rd;
    logic          sw_bad;
    logic          tx_pend;
    logic          tx_go;
    logic          expire;
    logic          hdr_last, hdr_wr, hdr_rd;
    logic [7:0]    hdr_ins;
    logic [7:0]    rd_byte;
    logic          wr_en;

    t0_atr_timer #(.DELAY(ATR_DELAY)) u_timer (
        .clk(clk), .rst_n(rst_n), .expire(expire)
    );

    t0_hdr_capture u_hdr (
        .clk(clk), .rst_n(rst_n),
        .shift_en(state == ST_HDR && rx_valid), .byte_in(rx_data),
        .last(hdr_last), .cmd_wr(hdr_wr), .cmd_rd(hdr_rd), .ins(hdr_ins)
    );

    t0_buffer_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(idx[AW-1:0]), .wdata(rx_data),
        .raddr(idx[AW-1:0]), .rdata(rd_byte)
    );

    // Handshake: a byte leaves only when the UART can take it.
    assign tx_pend = (state == ST_ATR0) || (state == ST_ATR1) || (state == ST_PROC) ||
                     (state == ST_RD)   || (state == ST_SW1)  || (state == ST_SW2);
    assign tx_go   = tx_pend && tx_ready;
    assign tx_req  = tx_go;
    assign wr_en   = (state == ST_WR) && rx_valid;

    // Select the byte offered in the current sending state.
    always_comb begin
        case (state)
            ST_ATR0: tx_data = ATR_FIRST;
            ST_ATR1: tx_data = ATR_LAST;
            ST_PROC: tx_data = hdr_ins;
            ST_RD:   tx_data = rd_byte;
            ST_SW1:  tx_data = sw_bad ? SW_BAD_HI : SW_OK_HI;
            ST_SW2:  tx_data = sw_bad ? SW_BAD_LO : SW_OK_LO;
            default: tx_data = 8'h00;
        endcase
    end

    // Sequence the exchange: delay, answer-to-reset, header, data, status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_WAIT;
            idx    <= '0;
            len    <= '0;
            is_rd  <= 1'b0;
            sw_bad <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: if (expire) state <= ST_ATR0;
                ST_ATR0: if (tx_go) state <= ST_ATR1;
                ST_ATR1: if (tx_go) state <= ST_HDR;
                ST_HDR: if (hdr_last) begin
                    idx    <= '0;
                    is_rd  <= hdr_rd;
                    sw_bad <= !(hdr_wr || hdr_rd);
                    // Write keeps raw P3 (0 = none); read maps 0 to full depth.
                    if (hdr_rd && rx_data == 8'h00) len <= IW'(DEPTH);
                    else                            len <= IW'(rx_data);
                    state  <= (hdr_wr || hdr_rd) ? ST_PROC : ST_SW1;
                end
                ST_PROC: if (tx_go) begin
                    if (is_rd)              state <= ST_RD;
                    else if (len == '0)     state <= ST_SW1;
                    else                    state <= ST_WR;
                end
                ST_WR: if (rx_valid) begin
                    idx <= idx + 1'b1;
                    if (idx + 1'b1 == len) state <= ST_SW1;
                end
                ST_RD: if (tx_go) begin
                    idx <= idx + 1'b1;
                    if (idx + 1'b1 == len) state <= ST_SW1;
                end
                ST_SW1: if (tx_go) state <= ST_SW2;
                ST_SW2: if (tx_go) state <= ST_HDR;
                default: state <= ST_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/t0_card_engine_chk.sv
// Property checker for t0_card_engine, attached by bind. Watches the
// transmit handshake, the quiet period and the answer-to-reset bytes.
module t0_card_engine_chk #(
    parameter int ATR_DELAY = 400
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_ready,
    input logic       tx_req,
    input logic [7:0] tx_data,
    input logic       tx_pend
);
    localparam int CW = $clog2(ATR_DELAY + 1);

    logic [CW-1:0] since_rst;
    logic [1:0]    sent;

    // Count edges since reset release and bytes handed over, both saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            sent      <= '0;
        end else begin
            if (since_rst != CW'(ATR_DELAY)) since_rst <= since_rst + 1'b1;
            if (tx_req && sent != 2'd2)      sent      <= sent + 1'b1;
        end
    end

    assert_req_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_ready);

    assert_byte_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pend && !tx_ready) |=> (tx_pend && $stable(tx_data)));

    assert_quiet_before_atr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(ATR_DELAY)) |-> !tx_req);

    assert_atr_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && sent == 2'd0) |-> (tx_data == 8'h3B));

    assert_atr_second_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && sent == 2'd1) |-> (tx_data == 8'h00));
endmodule

bind t0_card_engine t0_card_engine_chk #(.ATR_DELAY(ATR_DELAY)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready),
    .tx_req(tx_req), .tx_data(tx_data), .tx_pend(tx_pend)
);

// File: tb/sim_t0_card_engine.sv
`timescale 1ns/1ps
// Bench for t0_card_engine: a queue-based behavioural card model predicts
// tx_req/tx_data each cycle; results are compared away from the clock edge.
module sim_t0_card_engine;

    localparam int P_DELAY = 0, P_TX = 1, P_HDR = 2, P_WR = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_ready = 1'b1;
    logic       tx_req;
    logic [7:0] tx_data;

    int n_check = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    t0_card_engine u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_ready(tx_ready), .tx_req(tx_req), .tx_data(tx_data)
    );

    // ---------------- reference model ----------------
    int         m_phase = P_DELAY;
    int         m_next  = P_HDR;
    int         m_dcnt  = 0;
    int         m_wr_i  = 0;
    int         m_wr_n  = 0;
    bit         m_rst   = 1'b1;
    bit         started = 1'b0;
    logic [7:0] m_mem [256];
    bit         m_wrote [256];
    logic [7:0] txq [$];
    string      tagq [$];
    logic [7:0] hdr [$];

    task automatic push(input logic [7:0] b, input string t);
        txq.push_back(b);
        tagq.push_back(t);
    endtask

    task automatic decode();
        logic [31:0] w;
        int le;
        w = {hdr[0], hdr[1], hdr[2], hdr[3]};
        m_next = P_HDR;
        if (w == 32'h000C0000) begin
            push(hdr[1], "R5");
            if (hdr[4] == 8'h00) begin
                push(8'h90, "R7"); push(8'h00, "R7");
            end else begin
                m_next = P_WR; m_wr_i = 0; m_wr_n = int'(hdr[4]);
            end
        end else if (w == 32'h000A0000) begin
            push(hdr[1], "R5");
            le = (hdr[4] == 8'h00) ? 256 : int'(hdr[4]);
            for (int i = 0; i < le; i++)
                push(m_mem[i], !m_wrote[i] ? "R12" : (le == 256 ? "R9" : "R8"));
            push(8'h90, "R8"); push(8'h00, "R8");
        end else begin
            push(8'h69, "R10"); push(8'h86, "R10");
        end
        hdr.delete();
        m_phase = P_TX;
    endtask

    // Advance the model on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_phase = P_DELAY; m_dcnt = 0; m_rst = 1'b1;
            txq.delete(); tagq.delete(); hdr.delete();
            for (int i = 0; i < 256; i++) begin m_mem[i] = 8'h00; m_wrote[i] = 1'b0; end
        end else begin
            m_rst = 1'b0;
            case (m_phase)
                P_DELAY: begin
                    m_dcnt++;
                    if (m_dcnt == 400) begin
                        push(8'h3B, "R3"); push(8'h00, "R3");
                        m_phase = P_TX; m_next = P_HDR;
                    end
                end
                P_TX: if (tx_ready) begin
                    void'(txq.pop_front()); void'(tagq.pop_front());
                    if (txq.size() == 0) m_phase = m_next;
                end
                P_HDR: if (rx_valid) begin
                    hdr.push_back(rx_data);
                    if (hdr.size() == 5) decode();
                end
                P_WR: if (rx_valid) begin
                    m_mem[m_wr_i] = rx_data; m_wrote[m_wr_i] = 1'b1; m_wr_i++;
                    if (m_wr_i == m_wr_n) begin
                        push(8'h90, "R6"); push(8'h00, "R6");
                        m_phase = P_TX; m_next = P_HDR;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- stimulus driver ----------------
    logic [15:0] lfsr = 16'hACE1;
    bit          rdy_rand  = 1'b0;
    bit          gap_rand  = 1'b0;
    int          noise_lvl = 0;   // 0 none, 1 sparse, 2 every sending cycle
    logic [7:0]  stim_q [$];

    // Drive inputs at the falling edge from the stimulus queue and patterns.
    always @(negedge clk) begin
        lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready <= rdy_rand ? (lfsr[1] | lfsr[4]) : 1'b1;
        rx_valid <= 1'b0;
        if (rst_n) begin
            if ((m_phase == P_HDR || m_phase == P_WR) && stim_q.size() > 0
                && (!gap_rand || lfsr[7])) begin
                rx_valid <= 1'b1;
                rx_data  <= stim_q.pop_front();
            end else if ((m_phase == P_TX || m_phase == P_DELAY) &&
                         (noise_lvl == 2 || (noise_lvl == 1 && lfsr[9]))) begin
                rx_valid <= 1'b1;
                rx_data  <= lfsr[15:8];
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        #1;
        if (started && !done) begin
            logic       e_req;
            logic [7:0] e_dat;
            string      tg;
            e_req = (m_phase == P_TX) && tx_ready && (txq.size() > 0);
            e_dat = (txq.size() > 0) ? txq[0] : 8'h00;
            if (m_rst)                     tg = "R1";
            else if (m_phase == P_DELAY)   tg = "R2";
            else if (m_phase == P_TX)      tg = tx_ready ? tagq[0] : "R4";
            else                           tg = "R11";
            n_check++;
            if (tx_req !== e_req || (e_req && tx_data !== e_dat)) begin
                n_fail++;
                $display("FAIL %s: tx_req=%b tx_data=%02h expected tx_req=%b tx_data=%02h",
                         tg, tx_req, tx_data, e_req, e_dat);
            end
        end
    end

    // ---------------- sequence ----------------
    task automatic wait_idle();
        @(negedge clk); @(negedge clk);
        while (!(stim_q.size() == 0 && m_phase == P_HDR)) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] c, i, a, b, n);
        stim_q.push_back(c); stim_q.push_back(i); stim_q.push_back(a);
        stim_q.push_back(b); stim_q.push_back(n);
    endtask

    task automatic explicit_check(input bit ok, input string tg, input int act, input int exp);
        n_check++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tg, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_check, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 explicit_check(tx_req == 1'b0, "R1", int'(tx_req), 0);   // reset state
        rst_n = 1'b1;
        noise_lvl = 1;
        wait_idle();                                   // R2, R3 via model
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h04); wait_idle();   // R12 unwritten read
        rdy_rand = 1'b1; gap_rand = 1'b1;
        cmd(8'h00, 8'h0C, 8'h00, 8'h00, 8'h05);                // R6 write five
        stim_q.push_back(8'hAA); stim_q.push_back(8'h55); stim_q.push_back(8'h01);
        stim_q.push_back(8'hFE); stim_q.push_back(8'h80);
        wait_idle();
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h06); wait_idle();   // R8 read six
        cmd(8'h00, 8'h0C, 8'h00, 8'h00, 8'h00); wait_idle();   // R7 empty write
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h03); wait_idle();   // R7 store unchanged
        noise_lvl = 2;                                          // R11 collision phase
        cmd(8'h00, 8'h0B, 8'h00, 8'h00, 8'h00); wait_idle();   // R10 unknown INS
        cmd(8'h80, 8'h0C, 8'h00, 8'h00, 8'h01); wait_idle();   // R10 unknown CLA
        cmd(8'h00, 8'h0C, 8'h00, 8'h01, 8'h00); wait_idle();   // R10 unknown P2
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h02); wait_idle();   // R11 header after collision
        noise_lvl = 1;
        cmd(8'h00, 8'h0C, 8'h00, 8'h00, 8'hFF);                // R6 long write
        for (int k = 0; k < 255; k++) stim_q.push_back(8'(k) ^ 8'h5A);
        wait_idle();
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h00); wait_idle();   // R9 full read
        stim_q.push_back(8'h00); stim_q.push_back(8'h0A);      // R1 partial header, then reset
        repeat (6) @(negedge clk);
        stim_q.delete();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1 explicit_check(tx_req == 1'b0, "R1", int'(tx_req), 0);
        rst_n = 1'b1;
        wait_idle();                                            // R1 ATR again
        cmd(8'h00, 8'h0A, 8'h00, 8'h00, 8'h02); wait_idle();   // R1 store cleared
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

endmodule